// File: doc/BRIEF.md
# Register-Zero Substituting ALU

This block is the 24-bit arithmetic and logic stage of a small fixed-point processor. Each cycle it takes an operation code, three 4-bit register selectors (destination, first source, second source), the two operand values read from the register file and a ready-made 24-bit immediate. It does not read or write any register itself. Instead it works out which operands really apply, computes the result and raises a write enable for the register file.

Selector value zero does not name a register. As the second source it brings in the immediate. As the first source it brings in a literal zero, so that add, subtract, nor and the other operations become loads such as "dest = K", "dest = -second" or "dest = not second". As the destination it turns the operation into a compare: the flags are updated and nothing is written.

The block has no sequencing states. Its only state is the flag register (zero, negative, overflow), which follows two named transitions. In LOAD it captures new flags on a strobed add, subtract or logic operation. In HOLD it keeps the old flags on every other cycle. A 3-bit condition selector chooses one of eight conditions derived from the held flags. That condition gates the conditional moves.

Top module: `rzalu_top`

## Requirements
- R1: When the first-source selector is 0, the first operand is zero and the first-source data input has no effect; otherwise the first operand is the first-source data.
- R2: When the second-source selector is 0, the second operand is the immediate and the second-source data input has no effect; otherwise the second operand is the second-source data.
- R3: Opcode 4'b1010 gives first + second and 4'b1011 gives first - second, both modulo 2^24.
- R4: Opcode 4'b1100 gives AND, 4'b1101 OR, 4'b1110 NOR and 4'b1111 XOR of the two operands.
- R5: Opcode 4'b1000 gives second and 4'b1001 gives -second (conditional moves). Write enable rises only when the selected condition is true. The first operand is ignored.
- R6: A destination selector of 0 never raises write enable, but the flags are still loaded as for any other add, subtract or logic operation.
- R7: Write enable is high only when the strobe is high, opcode bit 3 is 1 and the destination selector is non-zero (subject to R5). Opcodes with bit 3 = 0 give result 0, no write and no flag load.
- R8: On a clock edge with the strobe high and an add, subtract or logic opcode, the zero flag loads (result == 0) and the negative flag loads result bit 23. In all other cycles, including conditional moves, the flags hold.
- R9: The overflow flag loads 1 on an add whose operands share a sign that differs from the result's sign. It loads 1 on a subtract whose operands differ in sign and whose result's sign differs from the first operand's sign. Logic operations load 0.
- R10: The condition selector picks 0 equal (Z), 1 not-equal (!Z), 2 overflow (V), 3 no-overflow (!V), 4 greater-or-equal (N==V), 5 greater-than (!Z and N==V), 6 less-or-equal (Z or N!=V), 7 less-than (N!=V).
- R11: While reset (active low) is asserted, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: the presented operation is executed this cycle |
| opcode | input | 4 | Operation code |
| sel_d | input | 4 | Destination selector (0 = compare only) |
| sel_s | input | 4 | First-source selector (0 = literal zero) |
| sel_t | input | 4 | Second-source selector (0 = immediate) |
| reg_s | input | 24 | First-source register data |
| reg_t | input | 24 | Second-source register data |
| imm_k | input | 24 | Immediate constant |
| cond_sel | input | 3 | Condition selector |
| result | output | 24 | Operation result |
| wr_en | output | 1 | Destination register write enable |
| flag_zero | output | 1 | Held zero flag |
| flag_neg | output | 1 | Held negative flag |
| flag_ovf | output | 1 | Held overflow flag |
| cond_true | output | 1 | Selected condition from held flags |

## Verification
Each of the eight computing opcodes is driven with plain register operands, and again with zero in each selector position, so that each substitution is tied to its own position. Every substitution case is driven with a garbage value on the replaced data input, which shows that input is ignored. Signed corner values (largest positive plus one, most negative minus one, equal operands) tell a correct overflow and zero rule apart from a carry-based or sign-only one. A logic operation just after an overflow shows the clearing. Conditional moves are run with the selected condition both true and false, and the flags are read afterwards to show they held. All eight conditions are read in three flag states with different N/V/Z combinations.

// File: rtl/rzalu_pkg.sv
package rzalu_pkg;
    localparam int DW  = 24;
    localparam int SW  = 4;
    localparam int OPW = 4;

    typedef enum logic [1:0] {
        GRP_CTRL  = 2'b00,
        GRP_MAC   = 2'b01,
        GRP_ARITH = 2'b10,
        GRP_LOGIC = 2'b11
    } op_group_e;

    typedef enum logic [2:0] {
        CND_EQ = 3'd0,
        CND_NE = 3'd1,
        CND_OV = 3'd2,
        CND_NV = 3'd3,
        CND_GE = 3'd4,
        CND_GT = 3'd5,
        CND_LE = 3'd6,
        CND_LT = 3'd7
    } cond_e;

    typedef enum logic {
        FL_HOLD = 1'b0,
        FL_LOAD = 1'b1
    } flag_step_e;
endpackage

// File: rtl/rzalu_operand_sel.sv
module rzalu_operand_sel #(
    parameter int DW = 24,
    parameter int SW = 4
) (
    input  logic [SW-1:0] sel_s,
    input  logic [SW-1:0] sel_t,
    input  logic [DW-1:0] reg_s,
    input  logic [DW-1:0] reg_t,
    input  logic [DW-1:0] imm_k,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] opb
);
    localparam logic [SW-1:0] SEL_ZERO = '0;

    always_comb begin
        opa = (sel_s == SEL_ZERO) ? '0    : reg_s;
        opb = (sel_t == SEL_ZERO) ? imm_k : reg_t;
    end

    // R1: zero selector in first position yields a zero operand
    always_comb begin
        if (sel_s == SEL_ZERO)
            assert_first_zero_R1: assert (opa == '0);
    end
endmodule

// File: rtl/rzalu_core.sv
module rzalu_core
    import rzalu_pkg::*;
#(
    parameter int DW  = 24,
    parameter int OPW = 4
) (
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    output logic [DW-1:0]  result,
    output logic           is_cmov,
    output logic           flag_upd,
    output logic           z_new,
    output logic           n_new,
    output logic           v_new
);
    localparam int MSB = DW - 1;

    op_group_e grp;
    logic [1:0] fn;
    logic [DW-1:0] sum, diff;

    always_comb begin
        grp  = op_group_e'(opcode[OPW-1:OPW-2]);
        fn   = opcode[1:0];
        sum  = opa + opb;
        diff = opa - opb;
        result   = '0;
        is_cmov  = 1'b0;
        flag_upd = 1'b0;
        v_new    = 1'b0;
        unique case (grp)
            GRP_ARITH: begin
                unique case (fn)
                    2'b00: begin result = opb;       is_cmov = 1'b1; end
                    2'b01: begin result = -opb;      is_cmov = 1'b1; end
                    2'b10: begin
                        result   = sum;
                        flag_upd = 1'b1;
                        v_new    = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
                    end
                    2'b11: begin
                        result   = diff;
                        flag_upd = 1'b1;
                        v_new    = (opa[MSB] != opb[MSB]) && (diff[MSB] != opa[MSB]);
                    end
                endcase
            end
            GRP_LOGIC: begin
                flag_upd = 1'b1;
                unique case (fn)
                    2'b00: result = opa & opb;
                    2'b01: result = opa | opb;
                    2'b10: result = ~(opa | opb);
                    2'b11: result = opa ^ opb;
                endcase
            end
            GRP_CTRL, GRP_MAC: result = '0;
        endcase
        z_new = (result == '0);
        n_new = result[MSB];
    end

    // R9: overflow only possible with equal-sign addends
    always_comb begin
        if (grp == GRP_ARITH && fn == 2'b10 && v_new)
            assert_add_ovf_signs_R9: assert (opa[MSB] == opb[MSB]);
    end
endmodule

// File: rtl/rzalu_flags.sv
module rzalu_flags
    import rzalu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       z_new,
    input  logic       n_new,
    input  logic       v_new,
    input  logic [2:0] cond_sel,
    output logic       flag_zero,
    output logic       flag_neg,
    output logic       flag_ovf,
    output logic       cond_true
);
    flag_step_e step;

    always_comb step = load ? FL_LOAD : FL_HOLD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_zero <= 1'b0;
            flag_neg  <= 1'b0;
            flag_ovf  <= 1'b0;
        end else begin
            unique case (step)
                FL_LOAD: begin
                    flag_zero <= z_new;
                    flag_neg  <= n_new;
                    flag_ovf  <= v_new;
                end
                FL_HOLD: ;
            endcase
        end
    end

    always_comb begin
        unique case (cond_e'(cond_sel))
            CND_EQ: cond_true = flag_zero;
            CND_NE: cond_true = !flag_zero;
            CND_OV: cond_true = flag_ovf;
            CND_NV: cond_true = !flag_ovf;
            CND_GE: cond_true = (flag_neg == flag_ovf);
            CND_GT: cond_true = !flag_zero && (flag_neg == flag_ovf);
            CND_LE: cond_true = flag_zero || (flag_neg != flag_ovf);
            CND_LT: cond_true = (flag_neg != flag_ovf);
        endcase
    end

    // R8: flags hold when not loaded
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({flag_zero, flag_neg, flag_ovf}));
endmodule

// File: rtl/rzalu_top.sv
module rzalu_top
    import rzalu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    opcode,
    input  logic [3:0]    sel_d,
    input  logic [3:0]    sel_s,
    input  logic [3:0]    sel_t,
    input  logic [23:0]   reg_s,
    input  logic [23:0]   reg_t,
    input  logic [23:0]   imm_k,
    input  logic [2:0]    cond_sel,
    output logic [23:0]   result,
    output logic          wr_en,
    output logic          flag_zero,
    output logic          flag_neg,
    output logic          flag_ovf,
    output logic          cond_true
);
    logic [DW-1:0] opa, opb;
    logic is_cmov, flag_upd, z_new, n_new, v_new, load;

    rzalu_operand_sel #(.DW(DW), .SW(SW)) opsel_i (
        .sel_s(sel_s), .sel_t(sel_t), .reg_s(reg_s), .reg_t(reg_t),
        .imm_k(imm_k), .opa(opa), .opb(opb)
    );

    rzalu_core #(.DW(DW), .OPW(OPW)) core_i (
        .opcode(opcode), .opa(opa), .opb(opb), .result(result),
        .is_cmov(is_cmov), .flag_upd(flag_upd),
        .z_new(z_new), .n_new(n_new), .v_new(v_new)
    );

    always_comb begin
        load  = op_valid && flag_upd;
        wr_en = op_valid && opcode[OPW-1] && (sel_d != '0) && (!is_cmov || cond_true);
    end

    rzalu_flags flags_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .z_new(z_new), .n_new(n_new), .v_new(v_new), .cond_sel(cond_sel),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf),
        .cond_true(cond_true)
    );

    assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_d == 4'd0) |-> !wr_en);

    assert_cmov_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:1] == 3'b100 && !cond_true) |-> !wr_en);

    assert_logic_clears_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[3:2] == 2'b11) |=> !flag_ovf);

    assert_zero_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[3] && opcode[3:1] != 3'b100) |=> (flag_zero == ($past(result) == '0)));

    assert_non_alu_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !opcode[3] |-> (!wr_en && result == '0));
endmodule

// File: tb/rzalu_top_tb_top.sv
module rzalu_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [3:0] opcode = '0, sel_d = '0, sel_s = '0, sel_t = '0;
    logic [23:0] reg_s = '0, reg_t = '0, imm_k = '0;
    logic [2:0] cond_sel = '0;
    logic [23:0] result;
    logic wr_en, flag_zero, flag_neg, flag_ovf, cond_true;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rzalu_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .sel_d(sel_d), .sel_s(sel_s), .sel_t(sel_t), .reg_s(reg_s),
        .reg_t(reg_t), .imm_k(imm_k), .cond_sel(cond_sel), .result(result),
        .wr_en(wr_en), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_ovf(flag_ovf), .cond_true(cond_true)
    );

    // {opcode, sd, ss, st, rs, rt, k, result, wr, Z, N, V}
    localparam int NV = 11;
    localparam logic [115:0] VEC [NV] = '{
        {4'hA, 4'd1, 4'd2, 4'd3, 24'h000010, 24'h000020, 24'h000999, 24'h000030, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 add
        {4'hA, 4'd1, 4'd2, 4'd0, 24'h000003, 24'hFFFFFF, 24'h000005, 24'h000008, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 imm
        {4'hA, 4'd1, 4'd2, 4'd3, 24'h7FFFFF, 24'h000001, 24'h000000, 24'h800000, 1'b1, 1'b0, 1'b1, 1'b1}, // R9 add ovf
        {4'hB, 4'd0, 4'd2, 4'd3, 24'h000005, 24'h000005, 24'h000000, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 compare
        {4'hB, 4'd2, 4'd2, 4'd3, 24'h800000, 24'h000001, 24'h000000, 24'h7FFFFF, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 sub ovf
        {4'hC, 4'd3, 4'd2, 4'd3, 24'hF0F0F0, 24'hFF00FF, 24'h000000, 24'hF000F0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 and, R9 clear
        {4'hB, 4'd3, 4'd0, 4'd3, 24'h123456, 24'h000010, 24'h000000, 24'hFFFFF0, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 negate
        {4'hD, 4'd4, 4'd2, 4'd0, 24'h000F00, 24'h00ABCD, 24'h0000F0, 24'h000FF0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 or imm
        {4'hE, 4'd4, 4'd0, 4'd3, 24'h555555, 24'h00FFFF, 24'h000000, 24'hFF0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 nor = not
        {4'hF, 4'd5, 4'd2, 4'd3, 24'hAAAAAA, 24'hAAAAAA, 24'h000000, 24'h000000, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 xor
        {4'h5, 4'd5, 4'd2, 4'd3, 24'h000001, 24'h000002, 24'h000003, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0}  // R7 non-ALU
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [3:0] d, input logic [3:0] s,
                         input logic [3:0] t, input logic [23:0] rs, input logic [23:0] rt,
                         input logic [23:0] k);
        @(negedge clk);
        op_valid = 1'b1; opcode = op; sel_d = d; sel_s = s; sel_t = t;
        reg_s = rs; reg_t = rt; imm_k = k;
        #1;
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic check_conds(input string req, input logic [7:0] exp);
        for (int c = 0; c < 8; c++) begin
            cond_sel = 3'(c);
            #1;
            chk(req, {23'd0, cond_true}, {23'd0, exp[c]});
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 Z", {23'd0, flag_zero}, 24'd0);
        chk("R11 N", {23'd0, flag_neg}, 24'd0);
        chk("R11 V", {23'd0, flag_ovf}, 24'd0);
        // R10: Z0 N0 V0 -> eq0 ne1 ov0 nv1 ge1 gt1 le0 lt0 (bit c = cond c)
        check_conds("R10 reset", 8'b0011_1010);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [115:0] v;
            v = VEC[i];
            drive(v[115:112], v[111:108], v[107:104], v[103:100], v[99:76], v[75:52], v[51:28]);
            chk("R1-4/R7 result", result, v[27:4]);
            chk("R6/R7 wr_en", {23'd0, wr_en}, {23'd0, v[3]});
            idle_cycle();
            chk("R8 flags", {21'd0, flag_zero, flag_neg, flag_ovf}, {21'd0, v[2:0]});
        end

        // R7: strobe low -> no write, flags hold (Z1 N0 V0)
        drive(4'hA, 4'd1, 4'd2, 4'd3, 24'h000001, 24'h000001, 24'h0);
        op_valid = 1'b0; #1;
        chk("R7 no strobe wr", {23'd0, wr_en}, 24'd0);
        @(posedge clk); #1;
        chk("R8 hold no strobe", {21'd0, flag_zero, flag_neg, flag_ovf}, 24'd4);

        // Compare 3-5 -> FFFFFE: Z0 N1 V0
        drive(4'hB, 4'd0, 4'd1, 4'd2, 24'h000003, 24'h000005, 24'h0);
        chk("R6 compare wr", {23'd0, wr_en}, 24'd0);
        idle_cycle();
        // R10: eq0 ne1 ov0 nv1 ge0 gt0 le1 lt1
        check_conds("R10 neg", 8'b1100_1010);

        // R5: cmov T with imm, cond lt true
        cond_sel = 3'd7;
        drive(4'h8, 4'd4, 4'd6, 4'd0, 24'hDEAD00, 24'h777777, 24'h000123);
        chk("R5 cmov result", result, 24'h000123);
        chk("R5 cmov taken", {23'd0, wr_en}, 24'd1);
        cond_sel = 3'd4; #1;
        chk("R5 cmov not taken", {23'd0, wr_en}, 24'd0);
        idle_cycle();
        chk("R8 cmov holds flags", {21'd0, flag_zero, flag_neg, flag_ovf}, 24'd2);

        // R5: cmov -T, cond lt
        cond_sel = 3'd7;
        drive(4'h9, 4'd4, 4'd5, 4'd1, 24'h123456, 24'h000002, 24'h0);
        chk("R5 cmov neg result", result, 24'hFFFFFE);
        chk("R5 cmov neg taken", {23'd0, wr_en}, 24'd1);
        sel_d = 4'd0; #1;
        chk("R6 cmov to zero dest", {23'd0, wr_en}, 24'd0);
        idle_cycle();
        chk("R8 cmov neg holds flags", {21'd0, flag_zero, flag_neg, flag_ovf}, 24'd2);

        // Overflow state Z0 N1 V1 via add 7FFFFF+1
        drive(4'hA, 4'd0, 4'd1, 4'd2, 24'h7FFFFF, 24'h000001, 24'h0);
        idle_cycle();
        // R10: eq0 ne1 ov1 nv0 ge1 gt1 le0 lt0
        check_conds("R10 ovf", 8'b0011_0110);

        // R11: reset again clears flags
        @(negedge clk);
        rst_n = 1'b0; #1;
        chk("R11 reset clears", {21'd0, flag_zero, flag_neg, flag_ovf}, 24'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule